// File: doc/BRIEF.md
# Clock Divider Update Sequencer

This block moves a group of clock divider registers to one of four performance levels. A single start pulse, together with a two-bit level index, begins a fixed walk over six divider groups. The groups are, in order, the core complex, the auxiliary core group, the memory controller, the top-level bus group, the left bus and the right bus. For each group the block reads the divider register and replaces only that group's divider fields with the values for the chosen level. It writes the word back and then polls the group's status register until every busy bit of that group reads zero. Only then does it move on to the next group.

The block drives a simple register port. A read returns its data one cycle after the request. A status poll that stays busy for too long aborts the whole sequence and raises a sticky error flag. When the last group's status clears, a one-cycle done pulse follows. The clock dividers themselves, and the PLL, sit outside this block.

Top module: `clkdiv_seq`

## Requirements
- R1: A sequence writes each group exactly once, in the order core complex (0), auxiliary core (1), memory controller (2), top bus (3), left bus (4), right bus (5). The divider register of group g sits at address 2g and its status register at address 2g+1.
- R2: Every group except the auxiliary core group has one 3-bit field in nibble k at bits [4k+2:4k], one field per level value. The core complex has 7 fields, the memory controller 8, the top bus 5 and each bus group 2. A write changes only those field bits and keeps every other bit of the word that was read back.
- R3: The auxiliary core group has two 3-bit fields: bits [6:4] are loaded with 3 and bits [2:0] with 0, at every level.
- R4: The field values for levels 0 to 3, listed from nibble 0 upward, are as follows. Core complex: 0,3,7,3,3,0,1 / 0,3,7,3,3,0,1 / 0,1,3,1,3,0,1 / 0,0,1,0,3,1,1. Memory controller: 3,1,1,1,1,1,3,1 / 3,1,1,1,1,1,3,1 / 7,1,1,2,1,1,3,1 / 7,1,1,3,1,1,3,1. Top bus: 3,7,4,5,1 / 3,7,4,5,1 / 4,7,5,7,1 / 5,7,7,7,1. Left bus and right bus, identical: 3,1 / 3,1 / 4,1 / 5,1.
- R5: A group's busy bits are bit 0 of each of its field nibbles. The next group is not touched until a status read shows all of those bits at zero. Status bits outside the mask are ignored.
- R6: If timeout_i consecutive status reads of one group show it busy, the block aborts: error_o goes high, no further group is written and no done pulse is given. A timeout_i of 0 acts as 1. A clear on the read that would have been the last allowed one counts as success. error_o stays high until the next accepted start.
- R7: busy_o rises on the edge that accepts start_i and stays high until the sequence finishes or aborts. Each group takes 3 cycles plus 2 cycles per status read.
- R8: start_i is ignored while busy_o is high. The level of the running sequence is kept, and no extra writes occur.
- R9: done_o is high for exactly one cycle: the first cycle after the last group's status clears, in which busy_o is already low. A start in that cycle is accepted.
- R10: While reset is asserted, busy_o, done_o, error_o and req_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a sequence (sampled while idle) |
| level_i | input | 2 | Performance level index 0..3 |
| timeout_i | input | TMO_W | Busy status reads allowed per group |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last group |
| error_o | output | 1 | Sticky abort flag after a poll timeout |
| req_o | output | 1 | Register access request |
| we_o | output | 1 | Access is a write |
| addr_o | output | 4 | 2*group for divider, 2*group+1 for status |
| wdata_o | output | 32 | Write data |
| rdata_i | input | 32 | Read data, valid the cycle after a read request |

## Verification
Two decisions can land in the same cycle. One is a status read that finds the group clear on exactly the read that would exhaust the timeout. The other is a new start arriving in the very cycle done_o pulses. The bench provokes the first by setting a group's busy duration to timeout_i minus one reads, and the case one read longer, and judges them by error_o, the write count and the exact busy length. It provokes the second by raising start_i in the done cycle and expects busy_o to return at the next edge and a second full, correctly ordered sequence.

// File: rtl/clkdiv_seq_pkg.sv
package clkdiv_seq_pkg;
  localparam int NUM_GRP = 6;
  localparam int GRP_W   = 3;
  localparam int LVL_W   = 2;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = GRP_W + 1;
  localparam int NIB_MAX = DATA_W / 4;

  localparam int GRP_FIELDS [NUM_GRP] = '{7, 2, 8, 5, 2, 2};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIV,
    ST_CAP,
    ST_WR_DIV,
    ST_RD_STAT,
    ST_CHK
  } seq_state_e;

  function automatic logic [DATA_W-1:0] nib_mask(int n, logic [3:0] pat);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < NIB_MAX; k++)
      if (k < n) m[4*k +: 4] = pat;
    return m;
  endfunction

  // field words, nibble k holds field k (aux core: fixed 3 at [6:4])
  function automatic logic [DATA_W-1:0] level_word(int g, logic [LVL_W-1:0] lvl);
    logic [DATA_W-1:0] w;
    w = '0;
    case (g)
      0: case (lvl)
           2'd0, 2'd1: w = 32'h0103_3730;
           2'd2:       w = 32'h0103_1310;
           default:    w = 32'h0113_0100;
         endcase
      1: w = 32'h0000_0030;
      2: case (lvl)
           2'd0, 2'd1: w = 32'h1311_1113;
           2'd2:       w = 32'h1311_2117;
           default:    w = 32'h1311_3117;
         endcase
      3: case (lvl)
           2'd0, 2'd1: w = 32'h0001_5473;
           2'd2:       w = 32'h0001_7574;
           default:    w = 32'h0001_7775;
         endcase
      default: case (lvl)
           2'd0, 2'd1: w = 32'h0000_0013;
           2'd2:       w = 32'h0000_0014;
           default:    w = 32'h0000_0015;
         endcase
    endcase
    return w;
  endfunction
endpackage

// File: rtl/clkdiv_seq_rom.sv
module clkdiv_seq_rom
  import clkdiv_seq_pkg::*;
(
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [GRP_W-1:0]  grp_i,
  output logic [DATA_W-1:0] word_o,
  output logic [DATA_W-1:0] fmask_o,
  output logic [DATA_W-1:0] bmask_o
);
  logic [DATA_W-1:0] word_tab  [NUM_GRP];
  logic [DATA_W-1:0] fmask_tab [NUM_GRP];
  logic [DATA_W-1:0] bmask_tab [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign word_tab[g]  = level_word(g, lvl_i);
    assign fmask_tab[g] = nib_mask(GRP_FIELDS[g], 4'h7);
    assign bmask_tab[g] = nib_mask(GRP_FIELDS[g], 4'h1);
  end

  always_comb begin
    word_o  = '0;
    fmask_o = '0;
    bmask_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grp_i == GRP_W'(g)) begin
        word_o  = word_tab[g];
        fmask_o = fmask_tab[g];
        bmask_o = bmask_tab[g];
      end
    end
  end
endmodule

// File: rtl/clkdiv_seq_tmr.sv
module clkdiv_seq_tmr #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   cnt_nxt;

  assign cnt_nxt  = {1'b0, cnt_q} + 1'b1;
  // limit 0 behaves as 1 because cnt_nxt is never below 1
  assign expire_o = hit_i && (cnt_nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (hit_i) cnt_q <= cnt_nxt[TMO_W-1:0];
  end
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_seq_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [TMO_W-1:0]  timeout_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i
);
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GRP - 1);

  seq_state_e        state_q;
  logic [GRP_W-1:0]  grp_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [DATA_W-1:0] shadow_q;
  logic              done_q, err_q;

  logic [DATA_W-1:0] word, fmask, bmask;
  logic              stat_clear, poll_hit, poll_expire;

  clkdiv_seq_rom u_rom (
    .lvl_i   (lvl_q),
    .grp_i   (grp_q),
    .word_o  (word),
    .fmask_o (fmask),
    .bmask_o (bmask)
  );

  assign stat_clear = ((rdata_i & bmask) == '0);
  assign poll_hit   = (state_q == ST_CHK) && !stat_clear;

  clkdiv_seq_tmr #(.TMO_W(TMO_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_WR_DIV),
    .hit_i    (poll_hit),
    .limit_i  (timeout_i),
    .expire_o (poll_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      grp_q    <= '0;
      lvl_q    <= '0;
      shadow_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          lvl_q   <= level_i;
          grp_q   <= '0;
          err_q   <= 1'b0;
          state_q <= ST_RD_DIV;
        end
        ST_RD_DIV:  state_q <= ST_CAP;
        ST_CAP: begin
          shadow_q <= rdata_i;
          state_q  <= ST_WR_DIV;
        end
        ST_WR_DIV:  state_q <= ST_RD_STAT;
        ST_RD_STAT: state_q <= ST_CHK;
        ST_CHK: begin
          if (stat_clear) begin
            if (grp_q == LAST_GRP) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              grp_q   <= grp_q + 1'b1;
              state_q <= ST_RD_DIV;
            end
          end else if (poll_expire) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_RD_STAT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;
  assign req_o   = (state_q == ST_RD_DIV) || (state_q == ST_WR_DIV) || (state_q == ST_RD_STAT);
  assign we_o    = (state_q == ST_WR_DIV);
  assign addr_o  = {grp_q, state_q == ST_RD_STAT};
  assign wdata_o = (shadow_q & ~fmask) | (word & fmask);
endmodule

// File: rtl/clkdiv_seq_chk.sv
module clkdiv_seq_chk
  import clkdiv_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic              req_o,
  input logic              we_o,
  input logic [ADDR_W-1:0] addr_o
);
  logic [GRP_W-1:0] exp_grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              exp_grp_q <= '0;
    else if (!busy_o)         exp_grp_q <= '0;
    else if (req_o && we_o)   exp_grp_q <= exp_grp_q + 1'b1;
  end

  AST_WRITE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o) |-> (addr_o == {exp_grp_q, 1'b0})); // R1

  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R7

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o); // R7

  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_ABORT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> (!busy_o && !done_o)); // R6
endmodule

bind clkdiv_seq clkdiv_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .error_o (error_o),
  .req_o   (req_o),
  .we_o    (we_o),
  .addr_o  (addr_o)
);

// File: tb/clkdiv_seq_test.sv
module clkdiv_seq_test;
  localparam int TMO_W = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  level_i = '0;
  logic [TMO_W-1:0] timeout_i = '0;
  logic        busy_o, done_o, error_o, req_o, we_o;
  logic [3:0]  addr_o;
  logic [31:0] wdata_o;
  logic [31:0] rdata = '0;

  clkdiv_seq #(.TMO_W(TMO_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .level_i(level_i),
    .timeout_i(timeout_i), .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
    .req_o(req_o), .we_o(we_o), .addr_o(addr_o), .wdata_o(wdata_o), .rdata_i(rdata)
  );

  always #2 clk = ~clk;

  // level values from nibble 0 upward
  localparam int CORE_V [4][7] = '{'{0,3,7,3,3,0,1}, '{0,3,7,3,3,0,1}, '{0,1,3,1,3,0,1}, '{0,0,1,0,3,1,1}};
  localparam int MEM_V  [4][8] = '{'{3,1,1,1,1,1,3,1}, '{3,1,1,1,1,1,3,1}, '{7,1,1,2,1,1,3,1}, '{7,1,1,3,1,1,3,1}};
  localparam int TOP_V  [4][5] = '{'{3,7,4,5,1}, '{3,7,4,5,1}, '{4,7,5,7,1}, '{5,7,7,7,1}};
  localparam int BUS_V  [4][2] = '{'{3,1}, '{3,1}, '{4,1}, '{5,1}};
  localparam int NFLD   [6]    = '{7,2,8,5,2,2};

  // lvl, seed sel, delay, timeout, slow group (7 none), slow delay
  localparam int NVEC = 7;
  localparam int VEC [NVEC][6] = '{
    '{0, 0, 0, 4, 7, 0},
    '{1, 1, 1, 4, 7, 0},
    '{2, 2, 2, 3, 7, 0},
    '{3, 3, 0, 1, 7, 0},
    '{2, 0, 1, 3, 2, 2},
    '{3, 1, 0, 3, 3, 3},
    '{0, 2, 0, 0, 1, 1}
  };

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [31:0] div_reg [6];
  logic [31:0] init_reg [6];
  int busy_left [6];
  int wr_log [16];
  int wr_cnt = 0;
  int cur_dly = 0, slow_g = 7, slow_d = 0;

  function automatic logic [31:0] fmask(int g);
    logic [31:0] m = '0;
    for (int k = 0; k < NFLD[g]; k++) m |= 32'h7 << (4*k);
    return m;
  endfunction

  function automatic logic [31:0] bmask(int g);
    logic [31:0] m = '0;
    for (int k = 0; k < NFLD[g]; k++) m |= 32'h1 << (4*k);
    return m;
  endfunction

  function automatic logic [31:0] exp_fields(int g, int lvl);
    logic [31:0] w = '0;
    for (int k = 0; k < NFLD[g]; k++) begin
      int v;
      case (g)
        0: v = CORE_V[lvl][k];
        2: v = MEM_V[lvl][k];
        3: v = TOP_V[lvl][k];
        default: v = BUS_V[lvl][k];
      endcase
      w |= 32'(v) << (4*k);
    end
    if (g == 1) w = 32'h30;
    return w;
  endfunction

  function automatic logic [31:0] seed_of(int s, int g);
    logic [31:0] b;
    case (s)
      0: b = 32'hFFFF_FFFF;
      1: b = 32'h0000_0000;
      2: b = 32'hA5A5_A5A5;
      default: b = 32'h5A5A_5A5A;
    endcase
    return b ^ (32'(g) << 29);
  endfunction

  // register model: divider at 2g, status at 2g+1, one-cycle read latency
  always @(posedge clk) begin
    if (req_o) begin
      int g;
      g = int'(addr_o[3:1]);
      if (g < 6) begin
        if (we_o) begin
          div_reg[g] = wdata_o;
          if (wr_cnt < 16) wr_log[wr_cnt] = g;
          wr_cnt++;
          busy_left[g] = (g == slow_g) ? slow_d : cur_dly;
        end else if (addr_o[0]) begin
          rdata <= ((busy_left[g] > 0) ? bmask(g) : 32'h0) | (32'h3333_3333 & ~bmask(g));
          if (busy_left[g] > 0) busy_left[g]--;
        end else begin
          rdata <= div_reg[g];
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act 0x%08h exp 0x%08h", req, act, exp);
    end
  endtask

  task automatic load_regs(input int s);
    for (int g = 0; g < 6; g++) begin
      div_reg[g]  = seed_of(s, g);
      init_reg[g] = div_reg[g];
      busy_left[g] = 0;
    end
    wr_cnt = 0;
  endtask

  // expected busy cycles and number of groups written
  task automatic predict(input int tout, output int cyc, output int nwr, output bit err);
    int teff;
    teff = (tout < 1) ? 1 : tout;
    cyc = 0; nwr = 0; err = 0;
    for (int g = 0; g < 6; g++) begin
      int d;
      if (err) break;
      d = (g == slow_g) ? slow_d : cur_dly;
      nwr++;
      if (d >= teff) begin
        cyc += 3 + 2*teff;
        err = 1;
      end else begin
        cyc += 3 + 2*(d+1);
      end
    end
  endtask

  task automatic run(input int lvl, input int tout, input bit b2b, input int mid_lvl);
    int ecyc, enwr, cyc;
    bit eerr;
    predict(tout, ecyc, enwr, eerr);
    if (!b2b) @(negedge clk);
    level_i = 2'(lvl); timeout_i = TMO_W'(tout); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R7 busy after start", 32'(busy_o), 1);
    chk(error_o === 1'b0, "R6 error cleared by start", 32'(error_o), 0);
    cyc = 1;
    while (busy_o === 1'b1 && cyc < 5000) begin
      if (cyc == 4 && mid_lvl >= 0) begin
        level_i = 2'(mid_lvl); start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      if (busy_o === 1'b1) cyc++;
    end
    start_i = 1'b0;
    chk(cyc == ecyc, "R7 busy length", 32'(cyc), 32'(ecyc));
    chk(done_o === !eerr, "R9 done pulse", 32'(done_o), 32'(!eerr));
    chk(error_o === eerr, "R6 error flag", 32'(error_o), 32'(eerr));
    chk(wr_cnt == enwr, "R8 write count", 32'(wr_cnt), 32'(enwr));
    for (int i = 0; i < wr_cnt && i < 16; i++)
      chk(wr_log[i] == i, "R1 group order", 32'(wr_log[i]), 32'(i));
    for (int g = 0; g < 6; g++) begin
      logic [31:0] e;
      e = (g < enwr) ? ((init_reg[g] & ~fmask(g)) | exp_fields(g, lvl)) : init_reg[g];
      if (g == 1) chk(div_reg[g] === e, "R3 aux core fields", div_reg[g], e);
      else        chk(div_reg[g] === e, "R2 R4 group word", div_reg[g], e);
    end
  endtask

  initial begin
    for (int g = 0; g < 6; g++) begin div_reg[g] = '0; init_reg[g] = '0; busy_left[g] = 0; end
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R10 reset busy/done", {busy_o, done_o}, 0);
    chk(error_o === 1'b0 && req_o === 1'b0, "R10 reset error/req", {error_o, req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      load_regs(VEC[v][1]);
      cur_dly = VEC[v][2]; slow_g = VEC[v][4]; slow_d = VEC[v][5];
      run(VEC[v][0], VEC[v][3], 1'b0, -1);
    end

    // R5: busy clears on the last allowed read (success) vs one read longer (abort)
    load_regs(3); cur_dly = 0; slow_g = 4; slow_d = 4;
    run(1, 5, 1'b0, -1);
    load_regs(3); cur_dly = 0; slow_g = 4; slow_d = 5;
    run(1, 5, 1'b0, -1);

    // R8: start with another level while busy is ignored
    load_regs(2); cur_dly = 1; slow_g = 7; slow_d = 0;
    run(3, 4, 1'b0, 0);

    // R9: start accepted in the done cycle
    load_regs(0); cur_dly = 0;
    run(2, 2, 1'b0, -1);
    load_regs(1);
    run(0, 2, 1'b1, -1);
    @(negedge clk);
    chk(done_o === 1'b0, "R9 done lasts one cycle", 32'(done_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule